// File: doc/BRIEF.md
# Event-Flag Serial Port

This block is a byte-wide serial port that sits on a 32-bit register bus. Software starts a transmission by writing a byte to the data register. The port then shifts that byte out on its transmit pin as an 8N1 frame. On the receive pin it rebuilds incoming 8N1 frames and keeps the most recent accepted byte in a single holding register, which software reads back through the same data register.

The port has no FIFO and no ready handshake. Completion is reported through two sticky event flags in the status register, one for receive and one for transmit. Software clears a flag by writing a one to its bit. Each flag has its own enable in the control register, and the enabled flags are combined into one level-sensitive interrupt line. A receive flag that is still set blocks the next byte. That byte is lost, and the byte already held is kept.

A divisor register sets the bit time, and the control and debug registers hold extra configuration bits that the port only stores.

Top module: `evt_uart`

## Requirements
- R1: After reset, the data, divisor, control and debug registers read 0, the status register reads 0x1, `irq` is 0 and `tx_o` is 1.
- R2: An access acts only when `bus_be` is 4'hF, the byte address is word aligned and the address is one of data 0x00, divisor 0x04, status 0x08, control 0x0C or debug 0x10. Any other access reads 0 and changes nothing.
- R3: The divisor, control and debug registers store and return the full 32-bit written value.
- R4: Status bit 0 always reads 1. Bit 1 is the receive event, bit 2 is the transmit event, and bits 31..3 read 0.
- R5: A status write clears bit 1 and/or bit 2 wherever the written bit is 1, and the other written bits have no effect. If an event is raised in the same cycle as its clear, the flag ends up set.
- R6: `irq` equals (receive event AND control bit 0) OR (transmit event AND control bit 1), and it is valid in the cycle after the clock edge that changed any of these.
- R7: A frame on `tx_o` is a 0 start bit, then the 8 data bits LSB first, then a 1 stop bit. Each bit lasts divisor×16 clocks, where a divisor of 0 acts as 1. The line idles at 1.
- R8: The transmit event is set at the clock edge that ends the stop bit, which is 10 bit times after the data-register write. A data write made while a frame is being sent is ignored.
- R9: `rx_i` passes through two synchronizer flops and is sampled at mid-bit. A valid frame puts its byte in data bits 7..0 (bits 31..8 read 0) and sets the receive event. A frame whose stop bit samples 0 is discarded.
- R10: A byte that completes while the receive event is set is dropped, and the data register keeps the earlier byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables, must be all ones |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not a valid read |
| irq | output | 1 | Level interrupt |
| tx_o | output | 1 | Serial transmit line |
| rx_i | input | 1 | Serial receive line |

## Verification
The bench clears the transmit event in the exact cycle the stop bit ends. A design that lets the clear win loses the completion silently. It writes a second byte halfway through a frame, which a design without the busy guard would either corrupt on the line or follow with an extra frame. It sends a frame with a zero stop bit and a second byte while the receive event is still pending. A wrong design would report the broken frame or overwrite the held byte. Partial-byte-enable, misaligned and out-of-range accesses show whether the decoder changes the plain registers or returns data where it should return zero. A divisor of 0 shows whether the bit timer stalls.

// File: rtl/evt_uart_pkg.sv
`timescale 1ns/1ps
package evt_uart_pkg;

  // Width of the divisor field that times the serial bits.
  localparam int DIV_W = 16;
  // Bit-period counter: divisor times 16 oversampling.
  localparam int CNT_W = DIV_W + 4;

  // Word index of each register (byte offset = index * 4).
  localparam int IDX_DATA   = 0;
  localparam int IDX_DIV    = 1;
  localparam int IDX_STATUS = 2;
  localparam int IDX_CTRL   = 3;
  localparam int IDX_DEBUG  = 4;
  localparam int REG_COUNT  = 5;

  // Registers that are plain storage, in slot order.
  localparam int PLAIN_N = 3;
  localparam int PLAIN_IDX [PLAIN_N] = '{IDX_DIV, IDX_CTRL, IDX_DEBUG};
  localparam int SLOT_DIV  = 0;
  localparam int SLOT_CTRL = 1;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  // Clocks per serial bit; a zero divisor is treated as one.
  function automatic logic [CNT_W-1:0] bit_clocks(input logic [DIV_W-1:0] div);
    logic [DIV_W-1:0] d;
    d = (div == '0) ? DIV_W'(1) : div;
    return {d, 4'b0000};
  endfunction

  // Clocks from a start edge to the middle of the start bit.
  function automatic logic [CNT_W-1:0] half_clocks(input logic [DIV_W-1:0] div);
    return bit_clocks(div) >> 1;
  endfunction

  function automatic logic irq_level(input logic rx_evt, input logic tx_evt,
                                     input logic rx_en, input logic tx_en);
    return (rx_evt & rx_en) | (tx_evt & tx_en);
  endfunction

  function automatic logic [31:0] status_word(input logic rx_evt, input logic tx_evt);
    return {29'b0, tx_evt, rx_evt, 1'b1};
  endfunction

endpackage

// File: rtl/evt_uart_regs.sv
`timescale 1ns/1ps
module evt_uart_regs
  import evt_uart_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]       bus_be,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             tx_busy,
  input  logic             tx_done,
  input  logic             rx_done,
  input  logic [7:0]       rx_byte,
  output logic             tx_start,
  output logic [7:0]       tx_byte,
  output logic [DIV_W-1:0] divisor,
  output logic             irq,
  output logic             acc_hit,
  output logic             wr_data,
  output logic             wr_status,
  output logic             rx_push,
  output logic             rx_clr_req,
  output logic             rx_evt,
  output logic             tx_evt,
  output logic [7:0]       rx_hold
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic             wr_en;
  logic             rd_en;
  logic             tx_clr_req;
  logic [31:0]      plain_q [PLAIN_N];
  logic [31:0]      rd_word;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign acc_hit = bus_sel && (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00)
                   && (widx < IDX_W'(REG_COUNT));
  assign wr_en   = acc_hit && bus_we;
  assign rd_en   = acc_hit && !bus_we;

  assign wr_data    = wr_en && (widx == IDX_W'(IDX_DATA));
  assign wr_status  = wr_en && (widx == IDX_W'(IDX_STATUS));
  assign rx_clr_req = wr_status && bus_wdata[1];
  assign tx_clr_req = wr_status && bus_wdata[2];

  // Transmit request: only accepted when the serializer is free.
  assign tx_start = wr_data && !tx_busy;
  assign tx_byte  = bus_wdata[7:0];

  // Receive acceptance: blocked while the previous byte is unacknowledged.
  assign rx_push = rx_done && !rx_evt;

  // Plain storage registers, one per slot.
  for (genvar k = 0; k < PLAIN_N; k++) begin : g_plain
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        plain_q[k] <= '0;
      end else if (wr_en && (widx == IDX_W'(PLAIN_IDX[k]))) begin
        plain_q[k] <= bus_wdata;
      end
    end
  end

  // Sticky event flags; a raise wins over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_evt  <= 1'b0;
      tx_evt  <= 1'b0;
      rx_hold <= '0;
    end else begin
      if (rx_push) begin
        rx_evt  <= 1'b1;
        rx_hold <= rx_byte;
      end else if (rx_clr_req) begin
        rx_evt <= 1'b0;
      end
      if (tx_done) begin
        tx_evt <= 1'b1;
      end else if (tx_clr_req) begin
        tx_evt <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (widx == IDX_W'(IDX_DATA)) begin
      rd_word = {24'h0, rx_hold};
    end
    if (widx == IDX_W'(IDX_STATUS)) begin
      rd_word = status_word(rx_evt, tx_evt);
    end
    for (int k = 0; k < PLAIN_N; k++) begin
      if (widx == IDX_W'(PLAIN_IDX[k])) begin
        rd_word = plain_q[k];
      end
    end
  end

  assign bus_rdata = rd_en ? rd_word : '0;
  assign divisor   = plain_q[SLOT_DIV][DIV_W-1:0];
  assign irq       = irq_level(rx_evt, tx_evt,
                               plain_q[SLOT_CTRL][0], plain_q[SLOT_CTRL][1]);

endmodule

// File: rtl/evt_uart_tx.sv
`timescale 1ns/1ps
module evt_uart_tx
  import evt_uart_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       byte_in,
  input  logic [DIV_W-1:0] div,
  output logic             tx_o,
  output logic             busy,
  output logic             done
);

  logic [8:0]       frame_q;   // data bits still to send, then stop bit
  logic [3:0]       left_q;    // bits remaining after the current one
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period_q;
  logic             line_q;
  logic             bit_end;

  assign bit_end = busy && (cnt_q == '0);
  assign done    = bit_end && (left_q == '0);
  assign tx_o    = line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      line_q   <= 1'b1;
      frame_q  <= '0;
      left_q   <= '0;
      cnt_q    <= '0;
      period_q <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      line_q   <= 1'b0;
      frame_q  <= {1'b1, byte_in};
      left_q   <= 4'd9;
      period_q <= bit_clocks(div);
      cnt_q    <= bit_clocks(div) - CNT_W'(1);
    end else if (busy) begin
      if (bit_end) begin
        if (left_q == '0) begin
          busy   <= 1'b0;
          line_q <= 1'b1;
        end else begin
          line_q  <= frame_q[0];
          frame_q <= {1'b1, frame_q[8:1]};
          left_q  <= left_q - 4'd1;
          cnt_q   <= period_q - CNT_W'(1);
        end
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/evt_uart_rx.sv
`timescale 1ns/1ps
module evt_uart_rx
  import evt_uart_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] div,
  output logic             done,
  output logic [7:0]       byte_out
);

  logic [1:0]       sync_q;
  logic             s_rx;
  logic             prev_q;
  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period_q;
  logic [2:0]       idx_q;
  logic [7:0]       shreg_q;
  logic             tick;

  assign s_rx     = sync_q[1];
  assign tick     = (cnt_q == '0);
  assign done     = (state_q == RX_STOP) && tick && s_rx;
  assign byte_out = shreg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= 2'b11;
      prev_q   <= 1'b1;
      state_q  <= RX_IDLE;
      cnt_q    <= '0;
      period_q <= '0;
      idx_q    <= '0;
      shreg_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      prev_q <= s_rx;
      case (state_q)
        RX_IDLE: begin
          if (prev_q && !s_rx) begin
            state_q  <= RX_START;
            period_q <= bit_clocks(div);
            cnt_q    <= half_clocks(div) - CNT_W'(1);
          end
        end
        RX_START: begin
          if (tick) begin
            if (!s_rx) begin
              state_q <= RX_DATA;
              idx_q   <= '0;
              cnt_q   <= period_q - CNT_W'(1);
            end else begin
              state_q <= RX_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        RX_DATA: begin
          if (tick) begin
            shreg_q <= {s_rx, shreg_q[7:1]};
            cnt_q   <= period_q - CNT_W'(1);
            if (idx_q == 3'd7) begin
              state_q <= RX_STOP;
            end else begin
              idx_q <= idx_q + 3'd1;
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        RX_STOP: begin
          if (tick) begin
            state_q <= RX_IDLE;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/evt_uart.sv
`timescale 1ns/1ps
module evt_uart
  import evt_uart_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              tx_o,
  input  logic              rx_i
);

  // Named internal events, also observed by the bound checker.
  logic             acc_hit;
  logic             wr_data;
  logic             wr_status;
  logic             rx_push;
  logic             rx_clr_req;
  logic             rx_evt;
  logic             tx_evt;
  logic [7:0]       rx_hold;
  logic             tx_start;
  logic [7:0]       tx_byte;
  logic             tx_busy;
  logic             tx_done;
  logic             rx_done;
  logic [7:0]       rx_byte;
  logic [DIV_W-1:0] divisor;

  evt_uart_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .tx_busy    (tx_busy),
    .tx_done    (tx_done),
    .rx_done    (rx_done),
    .rx_byte    (rx_byte),
    .tx_start   (tx_start),
    .tx_byte    (tx_byte),
    .divisor    (divisor),
    .irq        (irq),
    .acc_hit    (acc_hit),
    .wr_data    (wr_data),
    .wr_status  (wr_status),
    .rx_push    (rx_push),
    .rx_clr_req (rx_clr_req),
    .rx_evt     (rx_evt),
    .tx_evt     (tx_evt),
    .rx_hold    (rx_hold)
  );

  evt_uart_tx tx_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tx_start),
    .byte_in (tx_byte),
    .div     (divisor),
    .tx_o    (tx_o),
    .busy    (tx_busy),
    .done    (tx_done)
  );

  evt_uart_rx rx_u (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_i     (rx_i),
    .div      (divisor),
    .done     (rx_done),
    .byte_out (rx_byte)
  );

endmodule

// File: rtl/evt_uart_chk.sv
`timescale 1ns/1ps
module evt_uart_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              acc_hit,
  input logic              wr_data,
  input logic              wr_status,
  input logic              rx_clr_req,
  input logic              rx_push,
  input logic              rx_done,
  input logic              rx_evt,
  input logic              tx_evt,
  input logic [7:0]        rx_hold,
  input logic              tx_busy,
  input logic              tx_done,
  input logic              tx_o,
  input logic              irq
);

  // R2: a read that does not decode returns zero.
  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && !acc_hit) |-> (bus_rdata == 32'h0));

  // R4: a decoded status read always shows the transmit-empty bit.
  assert_thre_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && acc_hit && (bus_addr == ADDR_W'(8))) |-> bus_rdata[0]);

  // R5: a receive clear takes effect unless a byte is accepted in the same cycle.
  assert_rx_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && rx_clr_req && !rx_push) |=> !rx_evt);

  // R6: the interrupt never stands without a pending event.
  assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_evt || tx_evt));

  // R7: the line idles high and each frame begins with a low start bit.
  assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_o);
  assert_start_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !tx_o);

  // R8: a data write during a frame does not end or restart it.
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_busy && !tx_done) |=> (tx_busy && $stable(tx_o)));

  // R8: the transmit event only rises at the end of a frame.
  assert_tx_evt_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_evt) |-> $past(tx_done));

  // R9: the receive event only rises when a byte is accepted.
  assert_rx_evt_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_evt) |-> $past(rx_push));

  // R10: a byte completing while the flag is set leaves the held byte alone.
  assert_rx_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_evt) |=> $stable(rx_hold));

endmodule

bind evt_uart evt_uart_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .acc_hit    (acc_hit),
  .wr_data    (wr_data),
  .wr_status  (wr_status),
  .rx_clr_req (rx_clr_req),
  .rx_push    (rx_push),
  .rx_done    (rx_done),
  .rx_evt     (rx_evt),
  .tx_evt     (tx_evt),
  .rx_hold    (rx_hold),
  .tx_busy    (tx_busy),
  .tx_done    (tx_done),
  .tx_o       (tx_o),
  .irq        (irq)
);

// File: tb/evt_uart_tb_top.sv
`timescale 1ns/1ps
module evt_uart_tb_top;

  localparam int AW = 8;
  localparam logic [AW-1:0] A_DATA = 8'h00;
  localparam logic [AW-1:0] A_DIV  = 8'h04;
  localparam logic [AW-1:0] A_STAT = 8'h08;
  localparam logic [AW-1:0] A_CTRL = 8'h0C;
  localparam logic [AW-1:0] A_DBG  = 8'h10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [3:0]    bus_be = 4'hF;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq;
  logic          tx_o;
  logic          rx_i = 1'b1;

  int n_checks = 0;
  int n_errors = 0;

  // Bench-side model of the visible state.
  logic [31:0] m_ctrl = '0;
  logic [31:0] m_div  = '0;
  logic [31:0] m_dbg  = '0;
  logic        m_rx   = 1'b0;
  logic        m_tx   = 1'b0;
  logic [7:0]  m_data = '0;

  always #2.5 clk = ~clk;

  evt_uart #(.ADDR_W(AW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .tx_o      (tx_o),
    .rx_i      (rx_i)
  );

  function automatic logic [31:0] exp_status();
    logic [31:0] s;
    s = 32'h1;
    if (m_rx) s = s | 32'h2;
    if (m_tx) s = s | 32'h4;
    return s;
  endfunction

  function automatic logic exp_irq();
    return (m_rx && m_ctrl[0]) || (m_tx && m_ctrl[1]);
  endfunction

  function automatic int bit_time(input logic [31:0] d);
    int v;
    v = int'(d[15:0]);
    if (v == 0) v = 1;
    return v * 16;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d,
                           input logic [3:0] be = 4'hF);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_be = 4'hF;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d,
                          input logic [3:0] be = 4'hF);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0; bus_be = 4'hF;
  endtask

  task automatic send_rx(input int b, input logic [7:0] v, input logic stop);
    rx_i = 1'b0;
    repeat (b) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_i = v[i];
      repeat (b) @(negedge clk);
    end
    rx_i = stop;
    repeat (b) @(negedge clk);
    rx_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic recv_tx(input int b, output logic [7:0] got, output logic ok);
    int guard;
    guard = 0;
    ok = 1'b1;
    got = '0;
    while (tx_o !== 1'b0 && guard < 4 * b) begin
      @(negedge clk);
      guard++;
    end
    if (tx_o !== 1'b0) begin
      ok = 1'b0;
    end else begin
      repeat (b / 2) @(negedge clk);
      if (tx_o !== 1'b0) ok = 1'b0;
      for (int i = 0; i < 8; i++) begin
        repeat (b) @(negedge clk);
        got[i] = tx_o;
      end
      repeat (b) @(negedge clk);
      if (tx_o !== 1'b1) ok = 1'b0;
    end
  endtask

  task automatic check_state(input string req);
    logic [31:0] r;
    bus_read(A_STAT, r);
    chk({req, " status"}, r, exp_status());
    bus_read(A_DATA, r);
    chk({req, " data"}, r, {24'h0, m_data});
    bus_read(A_CTRL, r);
    chk({req, " ctrl"}, r, m_ctrl);
    bus_read(A_DIV, r);
    chk({req, " div"}, r, m_div);
    bus_read(A_DBG, r);
    chk({req, " debug"}, r, m_dbg);
    chk({req, " irq"}, {31'h0, irq}, {31'h0, exp_irq()});
  endtask

  task automatic tx_byte(input int b, input logic [7:0] v, input string req);
    logic [7:0] got;
    logic ok;
    bus_write(A_DATA, {24'hABCDEF, v});
    recv_tx(b, got, ok);
    chk({req, " tx byte"}, {24'h0, got}, {24'h0, v});
    chk({req, " tx framing"}, {31'h0, ok}, 32'h1);
    repeat (b / 2 + 2) @(negedge clk);
    m_tx = 1'b1;
  endtask

  task automatic rx_byte(input int b, input logic [7:0] v);
    send_rx(b, v, 1'b1);
    if (!m_rx) begin
      m_rx = 1'b1;
      m_data = v;
    end
  endtask

  // Watchdog: a hung run is a failed check and still reports.
  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  got;
    logic        ok;
    int          b;
    int          seed;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values.
    check_state("R1");
    chk("R1 tx idle", {31'h0, tx_o}, 32'h1);

    // R3: plain storage, full width.
    bus_write(A_DIV, 32'h5A5A_0002); m_div = 32'h5A5A_0002;
    bus_write(A_CTRL, 32'hF00D_BEE4); m_ctrl = 32'hF00D_BEE4;
    bus_write(A_DBG, 32'h1234_5679); m_dbg = 32'h1234_5679;
    check_state("R3");

    // R2: partial byte enables, misaligned and out-of-range accesses.
    bus_write(A_CTRL, 32'h0000_0003, 4'h3);
    bus_write(8'h0E, 32'hFFFF_FFFF);
    bus_write(8'h14, 32'hFFFF_FFFF);
    bus_write(8'hFC, 32'hFFFF_FFFF);
    bus_read(8'h14, r);
    chk("R2 unmapped read", r, 32'h0);
    bus_read(A_CTRL, r, 4'h1);
    chk("R2 partial read", r, 32'h0);
    bus_read(8'h0D, r);
    chk("R2 misaligned read", r, 32'h0);
    check_state("R2");

    // Divisor 2: 32 clocks per bit.
    bus_write(A_CTRL, 32'h0); m_ctrl = 32'h0;
    bus_write(A_DIV, 32'h2); m_div = 32'h2;
    b = bit_time(m_div);

    // R7/R8: frame content, then exact completion cycle with a racing clear (R5).
    tx_byte(b, 8'hC3, "R7");
    check_state("R8");
    bus_write(A_STAT, 32'h4); m_tx = 1'b0;
    check_state("R5 clear tx");

    bus_write(A_DATA, 32'h0000_0096);
    repeat (10 * b - 1) @(negedge clk);
    bus_read(A_STAT, r);
    chk("R8 no event before stop end", r & 32'h4, 32'h0);
    bus_write(A_STAT, 32'h4);
    m_tx = 1'b1;
    bus_read(A_STAT, r);
    chk("R5 raise beats clear", r & 32'h4, 32'h4);
    bus_write(A_STAT, 32'hFFFF_FFF9);
    bus_read(A_STAT, r);
    chk("R5 other bits no effect", r & 32'h4, 32'h4);
    bus_write(A_STAT, 32'h4); m_tx = 1'b0;

    // R8: a second write mid-frame is ignored, no extra frame follows.
    bus_write(A_DATA, 32'h0000_0011);
    fork
      recv_tx(b, got, ok);
      begin
        repeat (3 * b) @(negedge clk);
        bus_write(A_DATA, 32'h0000_00EE);
      end
    join
    chk("R8 first byte kept", {24'h0, got}, 32'h11);
    chk("R8 framing", {31'h0, ok}, 32'h1);
    repeat (b / 2 + 2) @(negedge clk);
    m_tx = 1'b1;
    ok = 1'b1;
    for (int i = 0; i < 3 * b; i++) begin
      if (tx_o !== 1'b1) ok = 1'b0;
      @(negedge clk);
    end
    chk("R8 no second frame", {31'h0, ok}, 32'h1);
    check_state("R8");

    // R6: enables against pending events.
    bus_write(A_CTRL, 32'h2); m_ctrl = 32'h2;
    chk("R6 tx irq", {31'h0, irq}, 32'h1);
    bus_write(A_CTRL, 32'h1); m_ctrl = 32'h1;
    chk("R6 masked tx", {31'h0, irq}, 32'h0);

    // R9: receive a byte; R6 via receive enable.
    rx_byte(b, 8'hA7);
    check_state("R9");
    chk("R6 rx irq", {31'h0, irq}, 32'h1);

    // R10: second byte while the flag is set is dropped.
    rx_byte(b, 8'h3C);
    check_state("R10");
    bus_write(A_STAT, 32'h6); m_rx = 1'b0; m_tx = 1'b0;
    check_state("R5 clear both");

    // R9: a zero stop bit discards the frame.
    send_rx(b, 8'h5A, 1'b0);
    check_state("R9 bad stop");
    rx_byte(b, 8'h81);
    check_state("R9 after bad stop");
    bus_write(A_STAT, 32'h2); m_rx = 1'b0;

    // R7: divisor 0 behaves as divisor 1.
    bus_write(A_DIV, 32'h0); m_div = 32'h0;
    tx_byte(16, 8'h4B, "R7 div0");
    bus_write(A_STAT, 32'h4); m_tx = 1'b0;

    // Randomized mix at divisor 1.
    bus_write(A_DIV, 32'h1); m_div = 32'h1;
    b = bit_time(m_div);
    seed = $urandom(32'h00C0_FFEE);
    for (int it = 0; it < 30; it++) begin
      int op;
      logic [31:0] v;
      op = $urandom_range(0, 5);
      v = $urandom();
      case (op)
        0: begin bus_write(A_CTRL, v); m_ctrl = v; end
        1: begin
          bus_write(A_STAT, v);
          if (v[1]) m_rx = 1'b0;
          if (v[2]) m_tx = 1'b0;
        end
        2: rx_byte(b, v[7:0]);
        3: tx_byte(b, v[7:0], "R7 rand");
        4: begin
          logic [AW-1:0] a;
          a = AW'(8'h14 + 4 * $urandom_range(0, 58));
          if (v[0]) a = {v[7:2], 2'b01 + 2'(v[1])};
          bus_write(a, v);
          bus_read(a, r);
          chk("R2 rand unmapped", r, 32'h0);
        end
        default: begin bus_write(A_DBG, v); m_dbg = v; end
      endcase
      check_state("R6 rand");
    end

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule